// File: doc/BRIEF.md
# Programmable Threshold Interrupt Generator

This block watches a stream of three-axis signed acceleration samples and raises an interrupt when a programmable combination of per-axis threshold events holds for enough consecutive samples. For each axis it checks the magnitude of the sample against a 7-bit threshold. If the magnitude is above the threshold, the axis has a high event. Otherwise it has a low event. Six enable bits pick which of these events take part. A mode pair then merges the enabled events in one of four ways: any event present (motion), all enabled events present (free-fall), a change in the set of events (movement between orientations), or exactly one event present (a resting position).

A duration counter requires the merged condition to hold on consecutive samples before the event is recognised. The result is reported in a source word, which holds the six event flags plus an active flag. It also drives an interrupt pin whose polarity and drive style are selectable. In latching mode the active state stays set until the source word is read. When auto-wake is enabled, each recognised event emits a one-cycle wake pulse that tells the power-mode logic to switch to the normal data rate.

Samples arrive on a valid/ready stream. The block never applies back-pressure: `smpl_ready` is high at all times, so every cycle with `smpl_valid` high consumes one sample. All state is updated on the clock edge that accepts a sample, or on the edge that sees a source read. The source word and the wake output are registered. The pin outputs are combinational from the active flag and the pin controls.

Top module: `accel_evt_irq`

## Requirements
- R1: The threshold is compared in sample units as `cfg_thr << (SAMPLE_W-1-THR_W)`. An axis has a high event when its magnitude is strictly greater than this value and a low event otherwise. The magnitude of the most negative sample is 2^(SAMPLE_W-1). Event bit positions are: bit 0 X low, bit 1 X high, bit 2 Y low, bit 3 Y high, bit 4 Z low, bit 5 Z high. Each bit is gated by the same bit of `cfg_en`.
- R2: With `cfg_dir`=0 and `cfg_and`=0, the condition is true when any enabled event is present.
- R3: With `cfg_dir`=0 and `cfg_and`=1, the condition is true when every enabled event is present. When `cfg_en` is zero, the condition is never true.
- R4: With `cfg_dir`=1 and `cfg_and`=0, the condition is true when the gated event set differs from the gated set of the previous accepted sample. That previous set is zero after reset.
- R5: With `cfg_dir`=1 and `cfg_and`=1, the condition is true when exactly one gated event is present.
- R6: An event is recognised on an accepted sample when the condition holds and at least `cfg_dur` earlier consecutive accepted samples also held it. A sample with a false condition restarts the count. With `cfg_dur`=0, the first qualifying sample is recognised.
- R7: With `cfg_latch`=0, every accepted sample sets the active flag (`src[6]`) to whether it was recognised. It sets `src[5:0]` to the gated events if it was recognised and to zero otherwise. `src_rd` has no effect in this mode.
- R8: With `cfg_latch`=1, a recognised event sets the active flag and loads the flags. They then hold until a cycle with `src_rd` high, which clears them. If a recognition and a read fall in the same cycle, the recognition wins.
- R9: In push-pull mode (`cfg_open_drain`=0), `irq_oe`=1 and `irq_o` equals the active flag XOR `cfg_act_low`. In open-drain mode, `irq_oe` equals the active flag and `irq_o` is the active level (NOT `cfg_act_low`).
- R10: When `cfg_wake`=2'b11, `wake_o` pulses high for the one cycle after each recognised event. With any other value it stays low.
- R11: After reset, `src` is zero, `wake_o` is low, the duration count and the previous event set are zero, and `smpl_ready` is high.
- R12: In a cycle with neither an accepted sample nor a read, `src` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smpl_valid | input | 1 | Sample stream valid |
| smpl_ready | output | 1 | Sample stream ready, always high |
| smpl_x | input | SAMPLE_W | X sample, two's complement |
| smpl_y | input | SAMPLE_W | Y sample, two's complement |
| smpl_z | input | SAMPLE_W | Z sample, two's complement |
| cfg_en | input | 6 | Event enables, bit order as in R1 |
| cfg_and | input | 1 | All-of merge select |
| cfg_dir | input | 1 | Orientation merge select |
| cfg_thr | input | THR_W | Threshold |
| cfg_dur | input | DUR_W | Minimum consecutive samples before recognition |
| cfg_latch | input | 1 | Hold active state until a source read |
| cfg_act_low | input | 1 | Pin polarity, 1 = active low |
| cfg_open_drain | input | 1 | Pin drive, 1 = open-drain |
| cfg_wake | input | 2 | Auto-wake field, 2'b11 enables |
| src_rd | input | 1 | Source word read strobe |
| src | output | 7 | {active, event flags[5:0]} |
| irq_o | output | 1 | Interrupt pin level |
| irq_oe | output | 1 | Interrupt pin drive enable |
| wake_o | output | 1 | Wake-to-normal-rate pulse |

## Verification
The bench builds the block with SAMPLE_W=10 and the default 7-bit threshold and duration fields. One threshold step is then 4 sample counts, so the boundary between "equal" and "one above" is easy to hit. The most negative sample (-512) lies above the largest scaled threshold, which makes the magnitude corner directly testable. A duration of 3 and a duration of 0 exercise the restart and first-sample cases. The reference model recomputes magnitudes with plain integers and compares every output on every cycle, across all four merge modes and all pin settings.

// File: rtl/accel_evt_pkg.sv
package accel_evt_pkg;
  localparam int N_AXES = 3;
  localparam int N_EVT  = 2 * N_AXES;

  typedef enum logic [1:0] {
    CMB_OR   = 2'b00,
    CMB_AND  = 2'b01,
    CMB_MOVE = 2'b10,
    CMB_POS  = 2'b11
  } cmb_mode_e;

  localparam logic [1:0] WAKE_ON = 2'b11;
endpackage

// File: rtl/accel_axis_cmp.sv
module accel_axis_cmp #(
  parameter int SAMPLE_W = 16,
  parameter int THR_W    = 7,
  localparam int SHIFT   = SAMPLE_W - 1 - THR_W
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic [THR_W-1:0]           thr,
  output logic                       above,
  output logic                       below
);
  logic [SAMPLE_W-1:0] mag;
  logic [SAMPLE_W-1:0] lim;

  always_comb begin
    // two's complement negate; the most negative value maps to 2^(W-1) unsigned
    mag   = sample[SAMPLE_W-1] ? (~$unsigned(sample) + 1'b1) : $unsigned(sample);
    lim   = SAMPLE_W'(thr) << SHIFT;
    above = (mag > lim);
    below = ~above;
  end
endmodule

// File: rtl/accel_evt_combine.sv
module accel_evt_combine
  import accel_evt_pkg::*;
(
  input  cmb_mode_e         mode,
  input  logic [N_EVT-1:0]  ev,
  input  logic [N_EVT-1:0]  en,
  input  logic [N_EVT-1:0]  prev,
  output logic              cond
);
  always_comb begin
    unique case (mode)
      CMB_OR:   cond = |ev;
      CMB_AND:  cond = (en != '0) && (ev == en);
      CMB_MOVE: cond = (ev != prev);
      CMB_POS:  cond = $onehot(ev);
      default:  cond = 1'b0;
    endcase
  end
endmodule

// File: rtl/accel_dwell_cnt.sv
module accel_dwell_cnt #(
  parameter int DUR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             cond,
  input  logic [DUR_W-1:0] dur,
  output logic             hit
);
  logic [DUR_W-1:0] cnt_q;

  assign hit = cond && (cnt_q >= dur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (step) begin
      if (!cond)          cnt_q <= '0;
      else if (cnt_q < dur) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/accel_irq_pad.sv
module accel_irq_pad (
  input  logic active,
  input  logic act_low,
  input  logic open_drain,
  output logic pin,
  output logic pin_oe
);
  always_comb begin
    if (open_drain) begin
      pin    = ~act_low;
      pin_oe = active;
    end else begin
      pin    = active ^ act_low;
      pin_oe = 1'b1;
    end
  end
endmodule

// File: rtl/accel_evt_irq.sv
module accel_evt_irq
  import accel_evt_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int THR_W    = 7,
  parameter int DUR_W    = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smpl_valid,
  output logic                       smpl_ready,
  input  logic signed [SAMPLE_W-1:0] smpl_x,
  input  logic signed [SAMPLE_W-1:0] smpl_y,
  input  logic signed [SAMPLE_W-1:0] smpl_z,
  input  logic [5:0]                 cfg_en,
  input  logic                       cfg_and,
  input  logic                       cfg_dir,
  input  logic [THR_W-1:0]           cfg_thr,
  input  logic [DUR_W-1:0]           cfg_dur,
  input  logic                       cfg_latch,
  input  logic                       cfg_act_low,
  input  logic                       cfg_open_drain,
  input  logic [1:0]                 cfg_wake,
  input  logic                       src_rd,
  output logic [6:0]                 src,
  output logic                       irq_o,
  output logic                       irq_oe,
  output logic                       wake_o
);
  logic signed [SAMPLE_W-1:0] axis_smp [N_AXES];
  logic [N_EVT-1:0] raw_ev;
  logic [N_EVT-1:0] ev;
  logic [N_EVT-1:0] prev_q;
  logic [N_EVT-1:0] flags_q;
  logic             act_q;
  logic             wake_q;
  logic             cond;
  logic             hit;
  logic             fire;
  cmb_mode_e        mode;

  assign smpl_ready  = 1'b1;
  assign axis_smp[0] = smpl_x;
  assign axis_smp[1] = smpl_y;
  assign axis_smp[2] = smpl_z;

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    accel_axis_cmp #(.SAMPLE_W(SAMPLE_W), .THR_W(THR_W)) u_cmp (
      .sample (axis_smp[a]),
      .thr    (cfg_thr),
      .above  (raw_ev[2*a+1]),
      .below  (raw_ev[2*a])
    );
  end

  assign ev   = raw_ev & cfg_en;
  assign mode = cmb_mode_e'({cfg_dir, cfg_and});

  accel_evt_combine u_cmb (
    .mode (mode),
    .ev   (ev),
    .en   (cfg_en),
    .prev (prev_q),
    .cond (cond)
  );

  accel_dwell_cnt #(.DUR_W(DUR_W)) u_dwell (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (smpl_valid),
    .cond  (cond),
    .dur   (cfg_dur),
    .hit   (hit)
  );

  assign fire = smpl_valid && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      flags_q <= '0;
      act_q   <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      wake_q <= fire && (cfg_wake == WAKE_ON);
      if (smpl_valid) prev_q <= ev;
      if (cfg_latch) begin
        if (fire) begin
          act_q   <= 1'b1;
          flags_q <= ev;
        end else if (src_rd) begin
          act_q   <= 1'b0;
          flags_q <= '0;
        end
      end else if (smpl_valid) begin
        act_q   <= fire;
        flags_q <= fire ? ev : '0;
      end
    end
  end

  assign src    = {act_q, flags_q};
  assign wake_o = wake_q;

  accel_irq_pad u_pad (
    .active     (act_q),
    .act_low    (cfg_act_low),
    .open_drain (cfg_open_drain),
    .pin        (irq_o),
    .pin_oe     (irq_oe)
  );
endmodule

// File: rtl/accel_evt_irq_chk.sv
module accel_evt_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       smpl_valid,
  input logic       cfg_latch,
  input logic       cfg_act_low,
  input logic       cfg_open_drain,
  input logic [1:0] cfg_wake,
  input logic       src_rd,
  input logic [6:0] src,
  input logic       irq_o,
  input logic       irq_oe,
  input logic       wake_o
);
  p_pushpull_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open_drain |-> (irq_oe && (irq_o == (src[6] ^ cfg_act_low))));

  p_opendrain_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_open_drain |-> ((irq_oe == src[6]) && (irq_o == !cfg_act_low)));

  p_wake_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (src[6] && $past(smpl_valid) && ($past(cfg_wake) == 2'b11)));

  p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_latch) && $past(src[6]) && !$past(src_rd)) |-> src[6]);

  p_latch_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_latch) && $past(src_rd) && !$past(smpl_valid)) |-> (src == 7'd0));

  p_idle_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(smpl_valid) && !$past(src_rd)) |-> $stable(src));
endmodule

bind accel_evt_irq accel_evt_irq_chk chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .smpl_valid     (smpl_valid),
  .cfg_latch      (cfg_latch),
  .cfg_act_low    (cfg_act_low),
  .cfg_open_drain (cfg_open_drain),
  .cfg_wake       (cfg_wake),
  .src_rd         (src_rd),
  .src            (src),
  .irq_o          (irq_o),
  .irq_oe         (irq_oe),
  .wake_o         (wake_o)
);

// File: tb/accel_evt_irq_tb.sv
module accel_evt_irq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 10;
  localparam int TW = 7;
  localparam int DW = 7;
  localparam int SHIFT = SW - 1 - TW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smpl_valid = 1'b0;
  logic smpl_ready;
  logic signed [SW-1:0] smpl_x = '0, smpl_y = '0, smpl_z = '0;
  logic [5:0] cfg_en = '0;
  logic cfg_and = 0, cfg_dir = 0, cfg_latch = 0, cfg_act_low = 0, cfg_open_drain = 0;
  logic [TW-1:0] cfg_thr = '0;
  logic [DW-1:0] cfg_dur = '0;
  logic [1:0] cfg_wake = '0;
  logic src_rd = 1'b0;
  logic [6:0] src;
  logic irq_o, irq_oe, wake_o;

  int checks = 0;
  int bad = 0;
  int cycles = 0;
  string cur_req = "R11";

  // reference model state
  int  m_cnt = 0;
  bit  m_act = 0;
  bit [5:0] m_flags = 0;
  bit [5:0] m_prev = 0;
  bit  m_wake = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  accel_evt_irq #(.SAMPLE_W(SW), .THR_W(TW), .DUR_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .smpl_valid(smpl_valid), .smpl_ready(smpl_ready),
    .smpl_x(smpl_x), .smpl_y(smpl_y), .smpl_z(smpl_z), .cfg_en(cfg_en),
    .cfg_and(cfg_and), .cfg_dir(cfg_dir), .cfg_thr(cfg_thr), .cfg_dur(cfg_dur),
    .cfg_latch(cfg_latch), .cfg_act_low(cfg_act_low), .cfg_open_drain(cfg_open_drain),
    .cfg_wake(cfg_wake), .src_rd(src_rd), .src(src), .irq_o(irq_o),
    .irq_oe(irq_oe), .wake_o(wake_o)
  );

  function automatic bit [1:0] axis_ev(int v, int lim);
    int m;
    m = (v < 0) ? -v : v;
    return (m > lim) ? 2'b10 : 2'b01;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_act = 0; m_flags = 0; m_prev = 0; m_wake = 0;
    end else begin
      bit [5:0] ev;
      bit cond;
      bit fire;
      int lim;
      lim  = int'(cfg_thr) * (1 << SHIFT);
      ev   = {axis_ev(int'(smpl_z), lim), axis_ev(int'(smpl_y), lim),
              axis_ev(int'(smpl_x), lim)} & cfg_en;
      fire = 0;
      if (smpl_valid) begin
        if (!cfg_dir && !cfg_and)     cond = (ev != 0);
        else if (!cfg_dir && cfg_and) cond = (cfg_en != 0) && (ev == cfg_en);
        else if (!cfg_and)            cond = (ev != m_prev);
        else                          cond = ($countones(ev) == 1);
        if (!cond) m_cnt = 0;
        else if (m_cnt >= int'(cfg_dur)) fire = 1;
        else m_cnt++;
        m_prev = ev;
      end
      m_wake = fire && (cfg_wake == 2'b11);
      if (cfg_latch) begin
        if (fire) begin m_act = 1; m_flags = ev; end
        else if (src_rd) begin m_act = 0; m_flags = 0; end
      end else if (smpl_valid) begin
        m_act = fire;
        m_flags = fire ? ev : 6'd0;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    bit eo, eoe;
    eo  = cfg_open_drain ? !cfg_act_low : (m_act ^ cfg_act_low);
    eoe = cfg_open_drain ? m_act : 1'b1;
    chk({cur_req, " src"}, int'(src), int'({m_act, m_flags}));
    chk({cur_req, " wake"}, int'(wake_o), int'(m_wake));
    chk({cur_req, " pin"}, int'({irq_oe, irq_o}), int'({eoe, eo}));
    chk({cur_req, " ready"}, int'(smpl_ready), 1);
  endtask

  task automatic cyc();
    @(negedge clk);
    compare_all();
  endtask

  task automatic smp(int x, int y, int z);
    smpl_x = SW'(x); smpl_y = SW'(y); smpl_z = SW'(z);
    smpl_valid = 1'b1;
    cyc();
    smpl_valid = 1'b0;
  endtask

  task automatic rd();
    src_rd = 1'b1;
    cyc();
    src_rd = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 20000);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    // R11 reset state
    chk("R11 src", int'(src), 0);
    chk("R11 wake", int'(wake_o), 0);
    chk("R11 pin", int'(irq_o), 0);

    // R1 / R2: X high only, threshold 10 -> limit 40
    cur_req = "R1"; cfg_thr = 7'd10; cfg_en = 6'b000010;
    smp(40, 0, 0);  chk("R1 equal not high", int'(src[6]), 0);
    smp(41, 0, 0);  chk("R1 above high", int'(src), 7'h42);
    smp(-41, 0, 0); chk("R1 negative magnitude", int'(src[6]), 1);
    smp(-512, 0, 0); cfg_thr = 7'd127; cyc();
    smp(-512, 0, 0); chk("R1 most negative above max", int'(src[6]), 1);
    cfg_thr = 7'd10;
    cur_req = "R2"; cfg_en = 6'b010101;
    smp(100, 100, 3); chk("R2 z low alone", int'(src), 7'h50);
    smp(100, 100, 100); chk("R2 none", int'(src), 0);
    cyc(); cur_req = "R12"; cyc(); chk("R12 idle holds", int'(src), 0);

    // R3 AND: all three low events
    cur_req = "R3"; cfg_and = 1; cfg_en = 6'b010101;
    smp(5, -5, 40);  chk("R3 all low", int'(src), 7'h55);
    smp(5, -5, 41);  chk("R3 one missing", int'(src[6]), 0);
    cfg_en = 6'b0;
    smp(0, 0, 0);    chk("R3 empty enables", int'(src[6]), 0);

    // R4 movement
    cur_req = "R4"; cfg_dir = 1; cfg_and = 0; cfg_en = 6'b111111;
    smp(100, 0, 0);  chk("R4 change", int'(src[6]), 1);
    smp(100, 0, 0);  chk("R4 same", int'(src[6]), 0);
    smp(0, 100, 0);  chk("R4 change again", int'(src[6]), 1);

    // R5 position: only high enables
    cur_req = "R5"; cfg_and = 1; cfg_en = 6'b101010;
    smp(0, 0, 100);  chk("R5 one", int'(src), 7'h60);
    smp(0, 100, 100); chk("R5 two", int'(src[6]), 0);

    // R6 duration 3
    cur_req = "R6"; cfg_dir = 0; cfg_and = 0; cfg_en = 6'b000010; cfg_dur = 7'd3;
    smp(90, 0, 0); smp(90, 0, 0); smp(90, 0, 0);
    chk("R6 not yet", int'(src[6]), 0);
    smp(90, 0, 0); chk("R6 fourth", int'(src[6]), 1);
    smp(0, 0, 0); smp(90, 0, 0); chk("R6 restart", int'(src[6]), 0);
    cfg_dur = 7'd0;
    smp(90, 0, 0); chk("R6 zero duration", int'(src[6]), 1);

    // R7 non-latched read has no effect
    cur_req = "R7";
    rd(); chk("R7 read ignored", int'(src[6]), 1);
    smp(0, 0, 0); chk("R7 follows sample", int'(src), 0);

    // R8 latched
    cur_req = "R8"; cfg_latch = 1;
    smp(90, 0, 0); smp(0, 0, 0); cyc();
    chk("R8 held", int'(src), 7'h42);
    src_rd = 1; smp(0, -90, 0); cfg_en = 6'b001010;
    chk("R8 held over read+no fire", int'(src[6]), 0);
    src_rd = 1; smp(0, -90, 0); src_rd = 0;
    chk("R8 fire wins", int'(src), 7'h48);
    rd(); chk("R8 cleared", int'(src), 0);

    // R9 pin variants
    cur_req = "R9"; cfg_latch = 0;
    for (int k = 0; k < 4; k++) begin
      cfg_act_low = k[0]; cfg_open_drain = k[1];
      smp(90, 0, 0); cyc();
      smp(0, 0, 0); cyc();
    end
    cfg_act_low = 0; cfg_open_drain = 0;

    // R10 wake
    cur_req = "R10"; cfg_wake = 2'b10;
    smp(90, 0, 0); chk("R10 off", int'(wake_o), 0);
    cfg_wake = 2'b11;
    smp(90, 0, 0); chk("R10 pulse", int'(wake_o), 1);
    cyc(); chk("R10 one cycle", int'(wake_o), 0);
    smp(0, 0, 0); chk("R10 no event", int'(wake_o), 0);

    // mixed stream
    cur_req = "R2";
    cfg_en = 6'b111111;
    for (int k = 0; k < 40; k++) begin
      cfg_dir = k[3]; cfg_and = k[2]; cfg_dur = DW'(k % 3);
      smp((k * 37) % 300 - 150, (k * 53) % 200 - 100, (k * 71) % 500 - 250);
      if (k % 5 == 0) cyc();
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule